// File: doc/BRIEF.md
# Dual-Threshold Supply State Controller

This block sets the operating state of a mixed-signal device from two supply comparators. One reports that the supply is above a low digital-reset level, and the other reports that it is above a higher analog-ready level. Below the reset level the logic is held in reset. Between the two levels the analog circuitry and the outputs are off. Above the analog-ready level the block enables the analog circuitry. The first time it gets there, it also asks for the shadowed nonvolatile settings to be copied into the working registers, and it enables the outputs only after that copy is acknowledged.

The copied settings stay valid through any dip that stays above the reset level. On recovery from such a dip, the block returns to normal operation with no new copy. A dip below the reset level clears the working registers and the valid flag, so the next rise above the analog-ready level starts a fresh copy. A not-ready status bit, meant for a serial-bus status register, is set while the analog-ready level is missing. It clears after a fixed settling count, which is derived from the clock frequency so that it stays below 500 microseconds.

Both comparator inputs are asynchronous and pass through two-flop synchronisers. The reset-level input asserts the internal reset asynchronously and releases it synchronously. All pins are plain control and status signals: there is no data stream and no valid/ready handshake. The copy request and its done pulse belong to the `clk` domain.

Top module: `supply_state_ctrl`

## Requirements
- R1: While `lvl_por_ok` is low, and for two clock edges after it rises, the outputs are `out_en`=0, `analog_en`=0, `recall_req`=0, `wreg_default`=1 and `not_ready`=1. `wreg_default` rises without waiting for a clock edge when `lvl_por_ok` falls.
- R2: On the first rise of `lvl_ana_ok` after reset, within three clock edges, `analog_en`=1 and `recall_req`=1, while `out_en` stays 0.
- R3: A `recall_done` sample taken while `recall_req`=1 and the analog level is present gives `recall_req`=0, `wreg_default`=0 and `out_en`=1 from that same edge on.
- R4: When `lvl_ana_ok` falls but `lvl_por_ok` stays high, `out_en` and `analog_en` go to 0 within three edges, and `wreg_default` stays 0.
- R5: After a dip of R4, a new rise of `lvl_ana_ok` brings back `out_en`=1 and `analog_en`=1 within three edges, and `recall_req` never asserts.
- R6: After `lvl_por_ok` has been low, the next rise of `lvl_ana_ok` asserts `recall_req` again, and `out_en` stays 0 until `recall_done`.
- R7: `not_ready` is 1 no later than three edges after `lvl_ana_ok` falls. After `lvl_ana_ok` rises, `not_ready` stays 1 for at least READY_CYCLES edges and reaches 0 by edge READY_CYCLES+2, where READY_CYCLES = (CLK_HZ/1e6)*READY_US.
- R8: If `lvl_ana_ok` falls while a copy is requested, `recall_req` and `analog_en` drop and the settings stay invalid (`wreg_default`=1). The request is made again on the next rise.
- R9: A `recall_done` pulse while no copy is requested is ignored: `wreg_default` stays 1, and the next rise of `lvl_ana_ok` still asserts `recall_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| lvl_por_ok | input | 1 | Async comparator: supply above the digital-reset level |
| lvl_ana_ok | input | 1 | Async comparator: supply above the analog-ready level |
| recall_done | input | 1 | One-cycle pulse: the settings copy has finished |
| out_en | output | 1 | Enable for the device outputs |
| analog_en | output | 1 | Enable for the analog circuitry |
| recall_req | output | 1 | Request to copy the shadowed settings into the working registers |
| wreg_default | output | 1 | Holds the working registers at their defaults; the shadow reads zero |
| not_ready | output | 1 | Status bit: the supply is not yet at a usable level |

## Verification
The supply inputs are driven through four patterns:
- a first power-up,
- a shallow dip that stays above the reset level,
- a deep dip below it,
- a loss of the analog level in the middle of a copy.

The shallow-dip and deep-dip patterns are the pair that tells a kept copy apart from one that was thrown away. After recovery from each, the bench watches whether `recall_req` comes back. A stray `recall_done` outside a request shows whether the handshake is gated by state. Exact-edge samples around the not-ready release show whether the settling count is too short or too long.

// File: rtl/supply_ctrl_pkg.sv
package supply_ctrl_pkg;
  typedef enum logic [1:0] {
    PS_WAIT = 2'd0,  // analog level absent
    PS_LOAD = 2'd1,  // copy of settings requested
    PS_RUN  = 2'd2   // normal operation
  } pstate_e;
endpackage

// File: rtl/ss_sync2.sv
module ss_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ready_timer.sv
module ready_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_ok,
  output logic not_ready
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!level_ok) begin
      cnt <= '0;
    end else if (cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign not_ready = (cnt != LIM);
endmodule

// File: rtl/supply_state_fsm.sv
module supply_state_fsm
  import supply_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ana_ok,
  input  logic recall_done,
  output logic out_en,
  output logic analog_en,
  output logic recall_req,
  output logic wreg_default
);
  pstate_e state, state_nx;
  logic    valid_q, valid_nx;

  always_comb begin
    state_nx = state;
    valid_nx = valid_q;
    unique case (state)
      PS_WAIT: if (ana_ok) state_nx = valid_q ? PS_RUN : PS_LOAD;
      PS_LOAD: begin
        if (!ana_ok) begin
          state_nx = PS_WAIT;
        end else if (recall_done) begin
          state_nx = PS_RUN;
          valid_nx = 1'b1;
        end
      end
      PS_RUN:  if (!ana_ok) state_nx = PS_WAIT;
      default: state_nx = PS_WAIT;
    endcase
  end

  // valid_q is cleared only by the reset-level condition (rst_n)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_WAIT;
      valid_q <= 1'b0;
    end else begin
      state   <= state_nx;
      valid_q <= valid_nx;
    end
  end

  assign out_en       = (state == PS_RUN);
  assign analog_en    = (state != PS_WAIT);
  assign recall_req   = (state == PS_LOAD);
  assign wreg_default = !valid_q;
endmodule

// File: rtl/supply_state_ctrl.sv
module supply_state_ctrl #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int READY_US = 400
) (
  input  logic clk,
  input  logic lvl_por_ok,
  input  logic lvl_ana_ok,
  input  logic recall_done,
  output logic out_en,
  output logic analog_en,
  output logic recall_req,
  output logic wreg_default,
  output logic not_ready
);
  localparam int READY_CYCLES = (CLK_HZ / 1_000_000) * READY_US;

  logic rst_n_sync;
  logic ana_ok;

  // reset: asserted at once, released through two flops
  ss_sync2 #(.W(1)) i_rst_sync (
    .clk(clk), .arst_n(lvl_por_ok), .d(1'b1), .q(rst_n_sync)
  );

  ss_sync2 #(.W(1)) i_ana_sync (
    .clk(clk), .arst_n(rst_n_sync), .d(lvl_ana_ok), .q(ana_ok)
  );

  supply_state_fsm i_fsm (
    .clk(clk), .rst_n(rst_n_sync), .ana_ok(ana_ok),
    .recall_done(recall_done), .out_en(out_en), .analog_en(analog_en),
    .recall_req(recall_req), .wreg_default(wreg_default)
  );

  ready_timer #(.CYCLES(READY_CYCLES)) i_rdy (
    .clk(clk), .rst_n(rst_n_sync), .level_ok(ana_ok), .not_ready(not_ready)
  );
endmodule

// File: rtl/supply_ctrl_chk.sv
module supply_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ana_ok,
  input logic recall_done,
  input logic out_en,
  input logic analog_en,
  input logic recall_req,
  input logic wreg_default,
  input logic not_ready
);
  // R3
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_req && recall_done && ana_ok) |=> (out_en && !recall_req && !wreg_default));

  // R4
  dip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_ok |=> (!out_en && !analog_en));

  // R5
  no_rerecall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wreg_default |-> !recall_req);

  // R6
  out_needs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !wreg_default);

  // R7
  not_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_ok |=> not_ready);

  // R2
  req_with_analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> (analog_en && !out_en));
endmodule

bind supply_state_ctrl supply_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n_sync), .ana_ok(ana_ok), .recall_done(recall_done),
  .out_en(out_en), .analog_en(analog_en), .recall_req(recall_req),
  .wreg_default(wreg_default), .not_ready(not_ready)
);

// File: tb/test_supply_state_ctrl.sv
`timescale 1ns/1ps
module test_supply_state_ctrl;
  localparam int K = 20;  // READY_CYCLES for CLK_HZ=1e6, READY_US=20

  logic clk = 1'b0;
  logic lvl_por_ok = 1'b0, lvl_ana_ok = 1'b0, recall_done = 1'b0;
  logic out_en, analog_en, recall_req, wreg_default, not_ready;
  int   total = 0, bad = 0;
  bit   seen_req = 0;

  always #10 clk = ~clk;  // 50 MHz

  supply_state_ctrl #(.CLK_HZ(1_000_000), .READY_US(20)) i_supply_state_ctrl (
    .clk(clk), .lvl_por_ok(lvl_por_ok), .lvl_ana_ok(lvl_ana_ok),
    .recall_done(recall_done), .out_en(out_en), .analog_en(analog_en),
    .recall_req(recall_req), .wreg_default(wreg_default), .not_ready(not_ready)
  );

  always @(posedge clk) if (recall_req === 1'b1) seen_req <= 1'b1;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // vector: {out_en, analog_en, recall_req, wreg_default, not_ready}
  task automatic chk(input string req, input logic [4:0] exp, input logic [4:0] msk);
    logic [4:0] act;
    act = {out_en, analog_en, recall_req, wreg_default, not_ready};
    total++;
    if ((act & msk) !== (exp & msk)) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b (mask %b)", req, act, exp, msk);
    end
  endtask

  task automatic pulse_done();
    recall_done = 1'b1;
    step(1);
    recall_done = 1'b0;
  endtask

  task automatic t_reset_state();
    step(3);
    chk("R1 held low", 5'b00011, 5'b11111);
    lvl_ana_ok = 1'b1;  // ignored while below reset level
    step(3);
    chk("R1 analog ignored", 5'b00011, 5'b11111);
    lvl_ana_ok = 1'b0;
    lvl_por_ok = 1'b1;
    step(2);
    chk("R1 after release", 5'b00011, 5'b11111);
  endtask

  task automatic t_stray_done();
    pulse_done();
    step(2);
    chk("R9 stray done", 5'b00011, 5'b11111);
    lvl_ana_ok = 1'b1;
    step(3);
    chk("R9 request still made", 5'b01111, 5'b11111);
    chk("R2 first rise", 5'b01110, 5'b11110);
  endtask

  task automatic t_complete_recall();
    recall_done = 1'b1;
    step(0);
    @(posedge clk);
    #1 chk("R3 same edge", 5'b11000, 5'b11110);
    @(negedge clk);
    recall_done = 1'b0;
    step(K + 2);
    chk("R3 settled", 5'b11000, 5'b11111);
  endtask

  task automatic t_shallow_dip();
    seen_req = 0;
    lvl_ana_ok = 1'b0;
    step(3);
    chk("R4 dip", 5'b00001, 5'b11111);
    chk("R7 set", 5'b00001, 5'b00001);
    lvl_ana_ok = 1'b1;
    step(K);
    chk("R7 still set", 5'b11001, 5'b11111);
    step(2);
    chk("R7 cleared", 5'b11000, 5'b11111);
    total++;
    if (seen_req) begin
      bad++;
      $display("FAIL R5: recall_req act=1 exp=0");
    end
  endtask

  task automatic t_deep_dip();
    lvl_por_ok = 1'b0;
    #1 chk("R1 async clear", 5'b00010, 5'b00010);
    lvl_ana_ok = 1'b0;
    step(2);
    chk("R6 low", 5'b00011, 5'b11111);
    lvl_por_ok = 1'b1;
    lvl_ana_ok = 1'b1;
    step(5);
    chk("R6 new request", 5'b01111, 5'b11111);
  endtask

  task automatic t_abort();
    lvl_ana_ok = 1'b0;
    step(3);
    chk("R8 abort", 5'b00011, 5'b11111);
    lvl_ana_ok = 1'b1;
    step(3);
    chk("R8 re-request", 5'b01111, 5'b11111);
    pulse_done();
    step(K + 2);
    chk("R8 done after retry", 5'b11000, 5'b11111);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_stray_done();
    t_complete_recall();
    t_shallow_dip();
    t_deep_dip();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule